// File: doc/BRIEF.md
# Controller status word with command-driven set and clear

This block keeps the state word of a serial controller: one bit that says whether the controller runs (operational) or is held for setup (configuration), one bit that picks the controller or the target role, and six sticky error flags. The flags record a mode error, a transmit overflow, a receive overflow, an abort, a transmit underflow and a receive underflow. A busy level from the shift engine is passed into the word without storage.

Software cannot load the word directly. It writes a command word instead. Each command bit asks for one action, which is either to set or to clear one status bit. Command bits are pulses, so a command write leaves no stored value behind. The engine's hardware error events also set the flags. Each of five of them is gated by its own enable bit in the control word, while a mode-error event is always taken. The block drives the status word, an error interrupt that is the OR of the six flags, and the operational and role levels.

Top module: `csb_status_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, all eight stored bits clear to 0, whatever the command and event inputs carry.
- R2: The status word places the stored bits at these positions: operational 0, role 1, mode error 7, transmit overflow 8, receive overflow 9, abort 10, transmit underflow 11, receive underflow 12. The position of `busy_in` is 13, and every other bit reads 0. `busy_in` appears there in the same cycle.
- R3: In a command write, bits 0/1 clear/set the operational bit, 2/3 clear/set the role bit, 4/5 clear/set receive underflow and 6/7 clear/set mode error. The change appears one clock after the write.
- R4: In a command write, bits 8, 9, 10 and 11 clear transmit overflow, receive overflow, abort and transmit underflow. Bits 12, 13, 14 and 15 set the same four flags in the same order.
- R5: If a set bit and its matching clear bit are both 1 in one write, the target bit keeps its value.
- R6: While `cmd_wr` is low, `cmd_data` has no effect on any status bit.
- R7: An event on `err_evt[k]` sets its flag at the next edge, where k is 0 mode, 1 tx overflow, 2 rx overflow, 3 abort, 4 tx underflow, 5 rx underflow. Events 1 to 5 need control bit 8, 9, 10, 11 or 12 respectively to be 1. Event 0 needs no enable.
- R8: An event that is taken in the same cycle as a clear command for its flag wins, and the flag ends set.
- R9: The flags hold their value in any cycle that has neither a command for them nor a taken event.
- R10: `err_irq` is 1 exactly when at least one of the six error flags is 1. `op_enable` and `master_sel` follow status bits 0 and 1.
- R11: One command write can clear several error flags at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe, one cycle per write |
| cmd_data | input | CMD_W (16) | Command word, one set or clear action per bit |
| ctrl_word | input | CTRL_W (16) | Control word; bits 8 to 12 enable error capture |
| err_evt | input | N_ERR (6) | Hardware error event pulses |
| busy_in | input | 1 | Busy level from the shift engine |
| status_word | output | STAT_W (16) | Assembled status word |
| err_irq | output | 1 | OR of the six error flags |
| op_enable | output | 1 | Operational (1) or configuration (0) level |
| master_sel | output | 1 | Role select level |

## Verification
The bench builds the block with its default widths: a 16-bit command and control word and six error inputs. The eight stored bits are few enough that each one can be swept through all 32 combinations of starting value, set bit, clear bit, event and enable. That sweep covers the set-with-clear hold, the priority of an event over a clear, and the gating by the control word. It also confirms that the seven untouched bits keep their value each time. Separate sweeps walk every single command bit, multi-bit clears, writes held off by a low strobe, and the busy pass-through.

// File: rtl/csb_pkg.sv
// Package: shared positions for the controller status bank.
// Flag index order inside the bank: 0 operational, 1 role, 2 mode error,
// 3 tx overflow, 4 rx overflow, 5 abort, 6 tx underflow, 7 rx underflow.
// Error event k maps to flag index k+2.
package csb_pkg;

    localparam int N_FLAG   = 8;
    localparam int BUSY_POS = 13;
    localparam int NO_GATE  = -1;

    // Status word bit position of flag i.
    function automatic int stat_pos(input int i);
        case (i)
            0:       return 0;
            1:       return 1;
            2:       return 7;
            default: return i + 5;
        endcase
    endfunction

    // Command bit that clears flag i.
    function automatic int clr_pos(input int i);
        case (i)
            0:       return 0;
            1:       return 2;
            2:       return 6;
            7:       return 4;
            default: return i + 5;
        endcase
    endfunction

    // Command bit that sets flag i.
    function automatic int set_pos(input int i);
        case (i)
            0:       return 1;
            1:       return 3;
            2:       return 7;
            7:       return 5;
            default: return i + 9;
        endcase
    endfunction

    // Control bit enabling hardware capture for flag i.
    function automatic int gate_pos(input int i);
        case (i)
            0, 1, 2: return NO_GATE;
            default: return i + 5;
        endcase
    endfunction

endpackage

// File: rtl/csb_cmd_decode.sv
// Module: csb_cmd_decode
// Turns one command write into per-flag set and clear pulses.
// Assumes the command word is wide enough for every position in csb_pkg.
module csb_cmd_decode
    import csb_pkg::*;
#(
    parameter int CMD_W = 16
) (
    input  logic              wr,
    input  logic [CMD_W-1:0]  cmd,
    output logic [N_FLAG-1:0] set_req,
    output logic [N_FLAG-1:0] clr_req
);

    for (genvar i = 0; i < N_FLAG; i++) begin : g_dec
        localparam int SP = set_pos(i);
        localparam int CP = clr_pos(i);
        // Pick this flag's two command bits, qualified by the strobe.
        assign set_req[i] = wr & cmd[SP];
        assign clr_req[i] = wr & cmd[CP];
    end

endmodule

// File: rtl/csb_evt_gate.sv
// Module: csb_evt_gate
// Qualifies hardware error events with their control enables and maps
// them onto flag indices. The mode-error event has no enable. The two
// level flags (operational, role) receive no events.
module csb_evt_gate
    import csb_pkg::*;
#(
    parameter int N_ERR  = 6,
    parameter int CTRL_W = 16
) (
    input  logic [N_ERR-1:0]  evt,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [N_FLAG-1:0] hit
);

    assign hit[1:0] = 2'b00;

    for (genvar k = 0; k < N_ERR; k++) begin : g_gate
        localparam int GP = gate_pos(k + 2);
        if (GP == NO_GATE) begin : g_free
            // Always taken.
            assign hit[k+2] = evt[k];
        end else begin : g_gated
            // Taken only with its control enable.
            assign hit[k+2] = evt[k] & ctrl[GP];
        end
    end

endmodule

// File: rtl/csb_flag_cell.sv
// Module: csb_flag_cell
// One sticky status bit. Priority: a taken event sets; otherwise a lone set
// or a lone clear acts; set with clear together holds.
module csb_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic evt_hit,
    output logic q
);

    // Update the bit with event-over-command priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                   q <= 1'b0;
        else if (evt_hit)             q <= 1'b1;
        else if (set_req && !clr_req) q <= 1'b1;
        else if (clr_req && !set_req) q <= 1'b0;
    end

endmodule

// File: rtl/csb_status_bank.sv
// Module: csb_status_bank (top)
// Holds the controller's operational, role and six error bits. They change
// only through command pulses and gated hardware events. Drives the status
// word, the error interrupt and the two level outputs. Assumes cmd_wr is one
// cycle per software write.
module csb_status_bank
    import csb_pkg::*;
#(
    parameter int CMD_W  = 16,
    parameter int CTRL_W = 16,
    parameter int N_ERR  = 6,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_data,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [N_ERR-1:0]  err_evt,
    input  logic              busy_in,
    output logic [STAT_W-1:0] status_word,
    output logic              err_irq,
    output logic              op_enable,
    output logic              master_sel
);

    localparam int ERR_LO = N_FLAG - N_ERR;

    logic [N_FLAG-1:0] set_req;
    logic [N_FLAG-1:0] clr_req;
    logic [N_FLAG-1:0] hit;
    logic [N_FLAG-1:0] flag_q;

    csb_cmd_decode #(.CMD_W(CMD_W)) u_dec (
        .wr      (cmd_wr),
        .cmd     (cmd_data),
        .set_req (set_req),
        .clr_req (clr_req)
    );

    csb_evt_gate #(.N_ERR(N_ERR), .CTRL_W(CTRL_W)) u_gate (
        .evt  (err_evt),
        .ctrl (ctrl_word),
        .hit  (hit)
    );

    for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
        csb_flag_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (set_req[i]),
            .clr_req (clr_req[i]),
            .evt_hit (hit[i]),
            .q       (flag_q[i])
        );
    end

    // Place the stored bits and the busy level into the status word.
    always_comb begin
        status_word = '0;
        for (int i = 0; i < N_FLAG; i++) status_word[stat_pos(i)] = flag_q[i];
        status_word[BUSY_POS] = busy_in;
    end

    // Error interrupt and the two level outputs.
    assign err_irq    = |flag_q[N_FLAG-1:ERR_LO];
    assign op_enable  = flag_q[0];
    assign master_sel = flag_q[1];

endmodule

// File: rtl/csb_status_bank_chk.sv
// Module: csb_status_bank_chk
// Assertion checker bound to csb_status_bank; observes ports only.
module csb_status_bank_chk #(
    parameter int CMD_W  = 16,
    parameter int CTRL_W = 16,
    parameter int N_ERR  = 6,
    parameter int STAT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr,
    input logic [CMD_W-1:0]  cmd_data,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic [N_ERR-1:0]  err_evt,
    input logic [STAT_W-1:0] status_word,
    input logic              err_irq,
    input logic              op_enable
);

    // R5: set and clear of the operational bit together hold it.
    a_r5_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_data[0] && cmd_data[1]) |=> (status_word[0] == $past(status_word[0])));

    // R8: a mode-error event leaves the flag set even with a clear.
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt[0] |=> status_word[7]);

    // R6: without a strobe and an event the stored bits hold.
    a_r6_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && err_evt == '0) |=> (status_word[12:0] == $past(status_word[12:0])));

    // R7: a gated-off tx overflow event without commands leaves the flag alone.
    a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && !ctrl_word[8]) |=> (status_word[8] == $past(status_word[8])));

    // R10: interrupt follows the six error flags.
    a_r10_irq: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq == (|status_word[12:7]));

    // R10: operational level follows its status bit.
    a_r10_level: assert property (@(posedge clk) disable iff (!rst_n)
        op_enable == status_word[0]);

endmodule

bind csb_status_bank csb_status_bank_chk #(
    .CMD_W(CMD_W), .CTRL_W(CTRL_W), .N_ERR(N_ERR), .STAT_W(STAT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .cmd_data    (cmd_data),
    .ctrl_word   (ctrl_word),
    .err_evt     (err_evt),
    .status_word (status_word),
    .err_irq     (err_irq),
    .op_enable   (op_enable)
);

// File: tb/csb_status_bank_tb.sv
// Bench for csb_status_bank: sweeps every flag through all combinations of
// start value, set, clear, event and enable against an arithmetic model.
module csb_status_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_data = '0;
    logic [15:0] ctrl_word = '0;
    logic [5:0]  err_evt = '0;
    logic        busy_in = 1'b0;
    logic [15:0] status_word;
    logic        err_irq, op_enable, master_sel;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model = '0;

    always #10 clk = ~clk;

    csb_status_bank u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .ctrl_word(ctrl_word), .err_evt(err_evt), .busy_in(busy_in),
        .status_word(status_word), .err_irq(err_irq),
        .op_enable(op_enable), .master_sel(master_sel)
    );

    // Tables from the requirements (R2, R3, R4, R7).
    function automatic int spos(input int i);
        int t [8] = '{0, 1, 7, 8, 9, 10, 11, 12};
        return t[i];
    endfunction
    function automatic int cpos(input int i);
        int t [8] = '{0, 2, 6, 8, 9, 10, 11, 4};
        return t[i];
    endfunction
    function automatic int ppos(input int i);
        int t [8] = '{1, 3, 7, 12, 13, 14, 15, 5};
        return t[i];
    endfunction
    function automatic int gpos(input int i);
        int t [8] = '{-1, -1, -1, 8, 9, 10, 11, 12};
        return t[i];
    endfunction

    function automatic logic [15:0] word_of(input logic [7:0] m, input logic b);
        logic [15:0] w = '0;
        for (int i = 0; i < 8; i++) w[spos(i)] = m[i];
        w[13] = b;
        return w;
    endfunction

    // Model update of one clock edge.
    function automatic logic [7:0] next_model(input logic [7:0] m, input logic wr,
        input logic [15:0] c, input logic [15:0] ct, input logic [5:0] ev);
        logic [7:0] n = m;
        for (int i = 0; i < 8; i++) begin
            logic s, r, h;
            s = wr && c[ppos(i)];
            r = wr && c[cpos(i)];
            h = 1'b0;
            if (i >= 2) h = ev[i-2] && (gpos(i) < 0 || ct[gpos(i)]);
            if (h) n[i] = 1'b1;
            else if (s && !r) n[i] = 1'b1;
            else if (r && !s) n[i] = 1'b0;
        end
        return n;
    endfunction

    task automatic check(input string req);
        logic [15:0] ew;
        ew = word_of(model, busy_in);
        n_chk++;
        if (status_word !== ew || err_irq !== (|model[7:2]) ||
            op_enable !== model[0] || master_sel !== model[1]) begin
            n_bad++;
            $display("FAIL %s: word=%h irq=%b en=%b ms=%b expected word=%h irq=%b en=%b ms=%b",
                req, status_word, err_irq, op_enable, master_sel,
                ew, |model[7:2], model[0], model[1]);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next fall.
    task automatic step(input logic wr, input logic [15:0] c, input logic [15:0] ct,
                        input logic [5:0] ev, input string req);
        cmd_wr = wr; cmd_data = c; ctrl_word = ct; err_evt = ev;
        @(negedge clk);
        if (rst_n) model = next_model(model, wr, c, ct, ev);
        cmd_wr = 1'b0; cmd_data = '0; err_evt = '0;
        check(req);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [15:0] all_set, all_clr;
        all_set = 16'hF0AA;
        all_clr = 16'h0F55;
        @(negedge clk);
        // R1: reset wins over commands and events.
        step(1'b1, all_set, 16'hFFFF, 6'h3F, "R1");
        rst_n = 1'b1;
        check("R1");

        // R3 R4: every single command bit, from all clear and all set.
        for (int b = 0; b < 16; b++) begin
            step(1'b1, all_clr, '0, '0, "R11");
            step(1'b1, 16'(1) << b, '0, '0, "R3 R4");
            step(1'b1, all_set, '0, '0, "R4");
            step(1'b1, 16'(1) << b, '0, '0, "R3 R4");
        end

        // R5 R7 R8 R9: per flag, every start/set/clear/event/enable mix.
        for (int f = 0; f < 8; f++) begin
            for (int v = 0; v < 32; v++) begin
                logic [15:0] c;
                logic [5:0] ev;
                logic wr;
                step(1'b1, v[0] ? all_set : all_clr, '0, '0, "R9");
                c = '0;
                if (v[1]) c[ppos(f)] = 1'b1;
                if (v[2]) c[cpos(f)] = 1'b1;
                wr = v[1] | v[2];
                ev = '0;
                if (v[3] && f >= 2) ev[f-2] = 1'b1;
                step(wr, c, v[4] ? 16'hFFFF : 16'h0000, ev, "R5 R7 R8 R9");
                step(1'b0, '0, '0, '0, "R9");
            end
        end

        // R6: full command word without a strobe.
        step(1'b1, all_set, '0, '0, "R6");
        step(1'b0, 16'hFFFF, '0, '0, "R6");
        step(1'b1, all_clr, '0, '0, "R6");
        step(1'b0, 16'hFFFF, '0, '0, "R6");

        // R7: all events with each single enable, and with none.
        for (int g = 7; g < 14; g++) begin
            step(1'b1, all_clr, '0, '0, "R7");
            step(1'b0, '0, (g == 13) ? 16'h0000 : (16'(1) << g), 6'h3F, "R7");
        end

        // R11: clear pairs and all errors in one write.
        for (int p = 0; p < 16; p++) begin
            step(1'b1, all_set, '0, '0, "R11");
            step(1'b1, {4'h0, p[3:0], 8'h00} | (p[0] ? 16'h0050 : 16'h0000), '0, '0, "R11");
        end

        // R2 R10: busy passes straight through.
        step(1'b1, 16'h0080, '0, '0, "R10");
        busy_in = 1'b1; #2; check("R2");
        busy_in = 1'b0; #2; check("R2");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule